// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block holds the register-level datapath of a small 32-bit load/store processor that executes add, sub, and, or, lw, sw, beq and j over several clock steps. One ALU does every calculation: PC increment, branch target, effective address, arithmetic and branch compare. One unified memory serves both instruction fetch and data access. Holding registers carry values from one step to the next: the instruction register, the memory data register, A, B and ALUOut.

An external controller drives every per-cycle control input. These are the register enables, the multiplexer selects and the ALU operation class. The controller reads back the opcode field of the held instruction and the ALU zero flag. The memory is a plain synchronous-write array. Before the program runs, a word-indexed preload port fills it.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low, the PC, IR, A, B, ALUOut and MDR registers and every register-file entry are zero.
- R2: The memory address is the PC when addr_sel_i=0 and ALUOut when addr_sel_i=1. The word index is address bits [MEM_AW+1:2].
- R3: The first ALU operand is the PC when src_a_sel_i=0 and A when src_a_sel_i=1.
- R4: The second ALU operand depends on src_b_sel_i: 00 gives B, 01 gives the constant 4, 10 gives the sign-extended IR[15:0], and 11 gives that value shifted left by 2.
- R5: alu_op_i=00 adds and 01 subtracts. For 10 and 11 the op follows IR[5:0]: 0x22 subtracts, 0x24 is bitwise and, 0x25 is bitwise or, and any other code, including 0x20, adds.
- R6: pc_src_i=00 loads the PC from the live ALU result and 01 from ALUOut. 10 and 11 load the jump target {PC[31:28], IR[25:0], 2'b00}.
- R7: The PC updates on a clock edge only when pc_write_i=1, or when pc_write_cond_i=1 and the ALU zero flag is 1. Otherwise it holds.
- R8: A loads reg[IR[25:21]] and B loads reg[IR[20:16]]. The write destination is IR[15:11] when dst_sel_i=1 and IR[20:16] when dst_sel_i=0. Register 0 reads zero, and writes to it are dropped.
- R9: Register write data is ALUOut when wb_sel_i=0 and MDR when wb_sel_i=1. It is written on a clock edge while reg_write_i=1.
- R10: While mem_write_i=1, B is written to the memory word at the selected address on the clock edge.
- R11: IR loads the memory read data only when ir_write_i=1. A, B, ALUOut and MDR load on every clock edge.
- R12: opcode_o is IR[31:26]. zero_o is 1 exactly when the live ALU result is zero.
- R13: While load_en_i=1, load_data_i is written to the memory word load_addr_i on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_write_i | input | 1 | Unconditional PC write |
| pc_write_cond_i | input | 1 | PC write when ALU zero |
| addr_sel_i | input | 1 | Memory address select (0 PC, 1 ALUOut) |
| mem_write_i | input | 1 | Store B to memory |
| ir_write_i | input | 1 | Instruction register load |
| reg_write_i | input | 1 | Register file write |
| dst_sel_i | input | 1 | Destination select (0 rt, 1 rd) |
| wb_sel_i | input | 1 | Write data select (0 ALUOut, 1 MDR) |
| src_a_sel_i | input | 1 | ALU operand A select |
| src_b_sel_i | input | 2 | ALU operand B select |
| alu_op_i | input | 2 | ALU operation class |
| pc_src_i | input | 2 | PC source select |
| load_en_i | input | 1 | Preload write enable |
| load_addr_i | input | MEM_AW | Preload word index |
| load_data_i | input | 32 | Preload data |
| opcode_o | output | 6 | IR[31:26] to controller |
| zero_o | output | 1 | ALU result is zero |
| pc_o | output | 32 | Current PC |
| alu_out_o | output | 32 | ALUOut register |

## Verification
A wrong holding register shows up at alu_out_o or zero_o one edge after the step that uses it. A wrong register-file entry or memory word only shows up when a later instruction reads it back through A, B or MDR, which is two to three steps after the read. A bad PC update shows on pc_o at the very next edge. A corrupted IR shows on opcode_o at once, and on the ALU path at the next step. The bench runs every instruction class through controller-like step sequences. It also drives unconstrained control words, so that each stray select or enable has a chance to diverge within a few cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR
  } alu_fn_e;

  localparam logic [5:0] FUNCT_SUB = 6'h22;
  localparam logic [5:0] FUNCT_AND = 6'h24;
  localparam logic [5:0] FUNCT_OR  = 6'h25;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;

  localparam logic [1:0] PCS_LIVE = 2'b00;
  localparam logic [1:0] PCS_HELD = 2'b01;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      class_i,
  input  logic [5:0]      funct_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  alu_fn_e fn;

  always_comb begin
    if (class_i == CLS_ADD) begin
      fn = FN_ADD;
    end else if (class_i == CLS_SUB) begin
      fn = FN_SUB;
    end else begin
      unique case (funct_i)
        FUNCT_SUB: fn = FN_SUB;
        FUNCT_AND: fn = FN_AND;
        FUNCT_OR:  fn = FN_OR;
        default:   fn = FN_ADD;
      endcase
    end
  end

  always_comb begin
    unique case (fn)
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [XLEN-1:0]   wd_i,
  output logic [XLEN-1:0]   da_o,
  output logic [XLEN-1:0]   db_o
);
  logic [XLEN-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  assign da_o = (ra_i == '0) ? '0 : rf_q[ra_i];
  assign db_o = (rb_i == '0) ? '0 : rf_q[rb_i];

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> rf_q[$past(wa_i)] == $past(wd_i));

  p_zero_reg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == '0) |-> da_o == '0);
endmodule

// File: rtl/mc_mem.sv
module mc_mem
  import mc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   idx_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wd_i,
  input  logic            ld_en_i,
  input  logic [AW-1:0]   ld_idx_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  logic [XLEN-1:0] mem_q [DEPTH];

  // preload port wins over a store in the same cycle
  always_ff @(posedge clk_i) begin
    if (ld_en_i)   mem_q[ld_idx_i] <= ld_data_i;
    else if (we_i) mem_q[idx_i]    <= wd_i;
  end

  assign rd_o = mem_q[idx_i];

  p_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ld_en_i) |=> mem_q[$past(idx_i)] == $past(wd_i));

  p_preload_r13: assert property (@(posedge clk_i)
    ld_en_i |=> mem_q[$past(ld_idx_i)] == $past(ld_data_i));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_write_i,
  input  logic              pc_write_cond_i,
  input  logic              addr_sel_i,
  input  logic              mem_write_i,
  input  logic              ir_write_i,
  input  logic              reg_write_i,
  input  logic              dst_sel_i,
  input  logic              wb_sel_i,
  input  logic              src_a_sel_i,
  input  logic [1:0]        src_b_sel_i,
  input  logic [1:0]        alu_op_i,
  input  logic [1:0]        pc_src_i,
  input  logic              load_en_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  output logic [5:0]        opcode_o,
  output logic              zero_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   alu_out_o
);
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
  logic [XLEN-1:0] src_a, src_b, alu_res, imm_ext, jmp_tgt, pc_next;
  logic [XLEN-1:0] mem_rdata, rf_da, rf_db, rf_wd;
  logic [MEM_AW-1:0] mem_idx;
  logic [REG_AW-1:0] rf_wa;
  logic alu_zero, pc_en;

  assign mem_idx = addr_sel_i ? alu_out_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];
  assign imm_ext = sext16(ir_q[15:0]);
  assign jmp_tgt = {pc_q[XLEN-1:28], ir_q[25:0], 2'b00};

  assign src_a = src_a_sel_i ? a_q : pc_q;

  always_comb begin
    unique case (src_b_sel_i)
      SRCB_REG:  src_b = b_q;
      SRCB_FOUR: src_b = XLEN'(4);
      SRCB_IMM:  src_b = imm_ext;
      default:   src_b = {imm_ext[XLEN-3:0], 2'b00};
    endcase
  end

  mc_alu u_alu (
    .a_i     (src_a),
    .b_i     (src_b),
    .class_i (alu_op_i),
    .funct_i (ir_q[5:0]),
    .res_o   (alu_res),
    .zero_o  (alu_zero)
  );

  always_comb begin
    unique case (pc_src_i)
      PCS_LIVE: pc_next = alu_res;
      PCS_HELD: pc_next = alu_out_q;
      default:  pc_next = jmp_tgt;
    endcase
  end

  assign pc_en = pc_write_i | (pc_write_cond_i & alu_zero);

  assign rf_wa = dst_sel_i ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = wb_sel_i ? mdr_q : alu_out_q;

  mc_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ir_q[25:21]),
    .rb_i   (ir_q[20:16]),
    .we_i   (reg_write_i),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd),
    .da_o   (rf_da),
    .db_o   (rf_db)
  );

  mc_mem #(.AW(MEM_AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (mem_idx),
    .we_i      (mem_write_i),
    .wd_i      (b_q),
    .ld_en_i   (load_en_i),
    .ld_idx_i  (load_addr_i),
    .ld_data_i (load_data_i),
    .rd_o      (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      ir_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
      mdr_q     <= '0;
    end else begin
      if (pc_en)      pc_q <= pc_next;
      if (ir_write_i) ir_q <= mem_rdata;
      a_q       <= rf_da;
      b_q       <= rf_db;
      alu_out_q <= alu_res;
      mdr_q     <= mem_rdata;
    end
  end

  assign opcode_o  = ir_q[31:26];
  assign zero_o    = alu_zero;
  assign pc_o      = pc_q;
  assign alu_out_o = alu_out_q;

  p_ir_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_write_i |=> $stable(ir_q));

  p_ir_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_i |=> ir_q == $past(mem_rdata));

  p_pc_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_write_i && !pc_write_cond_i) |=> $stable(pc_q));

  p_pc_nottaken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_cond_i && !pc_write_i && (alu_res != '0)) |=> $stable(pc_q));

  p_jump_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && pc_src_i[1]) |=> (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:28] == $past(pc_q[XLEN-1:28])));

  p_sub_class_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i == CLS_SUB) |-> alu_res == src_a - src_b);

  p_aluout_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> alu_out_q == $past(alu_res));
endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni;
  logic pc_write, pc_write_cond, addr_sel, mem_write, ir_write, reg_write;
  logic dst_sel, wb_sel, src_a_sel, load_en;
  logic [1:0] src_b_sel, alu_op, pc_src;
  logic [7:0] load_addr;
  logic [31:0] load_data;
  logic [5:0] opcode;
  logic zero;
  logic [31:0] pc, alu_out;

  mc_datapath dut (
    .clk_i(clk), .rst_ni(rst_ni), .pc_write_i(pc_write), .pc_write_cond_i(pc_write_cond),
    .addr_sel_i(addr_sel), .mem_write_i(mem_write), .ir_write_i(ir_write),
    .reg_write_i(reg_write), .dst_sel_i(dst_sel), .wb_sel_i(wb_sel),
    .src_a_sel_i(src_a_sel), .src_b_sel_i(src_b_sel), .alu_op_i(alu_op),
    .pc_src_i(pc_src), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .opcode_o(opcode), .zero_o(zero), .pc_o(pc),
    .alu_out_o(alu_out)
  );

  typedef struct packed {
    logic pcw, pcc, asel, mw, irw, rw, dst, wb, sa;
    logic [1:0] sb, op, ps;
  } ctl_t;

  logic [31:0] m_pc, m_ir, m_a, m_b, m_alu, m_mdr;
  logic [31:0] m_rf [32];
  logic [31:0] m_mem [256];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] calc(ctl_t c);
    logic [31:0] x, y, imm;
    imm = {{16{m_ir[15]}}, m_ir[15:0]};
    x = c.sa ? m_a : m_pc;
    case (c.sb)
      2'd0: y = m_b;
      2'd1: y = 32'd4;
      2'd2: y = imm;
      default: y = imm * 4;
    endcase
    if (c.op == 2'd0) return x + y;
    if (c.op == 2'd1) return x - y;
    case (m_ir[5:0])
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      default: return x + y;
    endcase
  endfunction

  task automatic model_step(ctl_t c);
    logic [31:0] res, addr, rdata, npc, ra, rb;
    int idx;
    int dest;
    res = calc(c);
    addr = c.asel ? m_alu : m_pc;
    idx = int'(addr[9:2]);
    rdata = m_mem[idx];
    npc = m_pc;
    if (c.pcw || (c.pcc && res == 0)) begin
      if (c.ps == 2'd0) npc = res;
      else if (c.ps == 2'd1) npc = m_alu;
      else npc = {m_pc[31:28], m_ir[25:0], 2'b00};
    end
    ra = m_rf[int'(m_ir[25:21])];
    rb = m_rf[int'(m_ir[20:16])];
    dest = c.dst ? int'(m_ir[15:11]) : int'(m_ir[20:16]);
    if (c.rw && dest != 0) m_rf[dest] = c.wb ? m_mdr : m_alu;
    if (c.mw) m_mem[idx] = m_b;
    if (c.irw) m_ir = rdata;
    m_a = ra; m_b = rb; m_alu = res; m_mdr = rdata; m_pc = npc;
  endtask

  task automatic cyc(ctl_t c, string tag);
    logic [31:0] r;
    {pc_write, pc_write_cond, addr_sel, mem_write, ir_write, reg_write, dst_sel, wb_sel,
     src_a_sel, src_b_sel, alu_op, pc_src} = c;
    #1;
    r = calc(c);
    chk({tag, " R12 zero"}, {31'b0, zero}, {31'b0, (r == 0)});
    model_step(c);
    @(negedge clk);
    chk({tag, " R2 R6 R7 pc"}, pc, m_pc);
    chk({tag, " R3 R4 R5 R8 R9 R10 aluout"}, alu_out, m_alu);
    chk({tag, " R11 R12 opcode"}, {26'b0, opcode}, {26'b0, m_ir[31:26]});
  endtask

  function automatic ctl_t k_fetch();
    ctl_t c = '0; c.irw = 1; c.sb = 2'd1; c.pcw = 1; return c;
  endfunction
  function automatic ctl_t k_decode();
    ctl_t c = '0; c.sb = 2'd3; return c;
  endfunction
  function automatic ctl_t k_maddr();
    ctl_t c = '0; c.sa = 1; c.sb = 2'd2; return c;
  endfunction

  task automatic run_lw();
    ctl_t c;
    cyc(k_fetch(), "lw fetch");
    cyc(k_decode(), "lw decode");
    cyc(k_maddr(), "lw addr");
    c = k_maddr(); c.asel = 1; cyc(c, "lw read");
    c.rw = 1; c.wb = 1; c.dst = 0; cyc(c, "lw wb R9");
  endtask

  task automatic run_sw();
    ctl_t c;
    cyc(k_fetch(), "sw fetch");
    cyc(k_decode(), "sw decode");
    cyc(k_maddr(), "sw addr");
    c = k_maddr(); c.asel = 1; c.mw = 1; cyc(c, "sw store R10");
  endtask

  task automatic run_r();
    ctl_t c;
    cyc(k_fetch(), "r fetch");
    cyc(k_decode(), "r decode");
    c = '0; c.sa = 1; c.op = 2'd2; cyc(c, "r exec");
    c.rw = 1; c.dst = 1; c.wb = 0; cyc(c, "r done");
  endtask

  task automatic run_beq();
    ctl_t c;
    cyc(k_fetch(), "beq fetch");
    cyc(k_decode(), "beq decode");
    c = '0; c.sa = 1; c.op = 2'd1; c.pcc = 1; c.ps = 2'd1; cyc(c, "beq cmp");
  endtask

  task automatic run_j();
    ctl_t c;
    cyc(k_fetch(), "j fetch");
    cyc(k_decode(), "j decode");
    c = '0; c.pcw = 1; c.ps = 2'd2; cyc(c, "j jump");
  endtask

  function automatic logic [31:0] prog(int i);
    case (i)
      0: return 32'h8C010100;  // lw  r1,0x100(r0)
      1: return 32'h8C020104;  // lw  r2,0x104(r0)
      2: return 32'h00221820;  // add r3,r1,r2
      3: return 32'hAC030108;  // sw  r3,0x108(r0)
      4: return 32'h10210002;  // beq r1,r1,+2
      7: return 32'h08000009;  // j   word 9
      9: return 32'h8C040108;  // lw  r4,0x108(r0)
      10: return 32'h00802820; // add r5,r4,r0
      11: return 32'h00220020; // add r0,r1,r2
      12: return 32'h00013020; // add r6,r0,r1
      13: return 32'h10220001; // beq r1,r2,+1
      14: return 32'h00413822; // sub r7,r2,r1
      15: return 32'h00224024; // and r8,r1,r2
      16: return 32'h00224825; // or  r9,r1,r2
      64: return 32'd5;
      65: return 32'd7;
      default: return (i * 32'h01010101) ^ 32'h5A3C0000;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ctl_t c;
    rst_ni = 0;
    {pc_write, pc_write_cond, addr_sel, mem_write, ir_write, reg_write, dst_sel, wb_sel,
     src_a_sel, src_b_sel, alu_op, pc_src} = '0;
    load_en = 0; load_addr = '0; load_data = '0;
    m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_alu = 0; m_mdr = 0;
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      load_en = 1; load_addr = 8'(i); load_data = prog(i);
      m_mem[i] = prog(i);
      @(negedge clk);
    end
    load_en = 0;
    chk("R1 reset pc", pc, 32'h0);
    chk("R1 reset aluout", alu_out, 32'h0);
    chk("R1 reset opcode", {26'b0, opcode}, 32'h0);
    chk("R1 reset zero", {31'b0, zero}, 32'h1);
    rst_ni = 1;
    @(negedge clk);

    run_lw();
    run_lw();
    run_r();
    chk("R5 add result", alu_out, 32'd12);
    run_sw();
    run_beq();
    chk("R7 branch taken pc", pc, 32'd28);
    run_j();
    chk("R6 jump target pc", pc, 32'd36);
    run_lw();
    run_r();
    chk("R10 stored word read back", alu_out, 32'd12);
    run_r();
    run_r();
    chk("R8 r0 ignores write, reads zero", alu_out, 32'd5);
    run_beq();
    chk("R7 branch not taken pc", pc, 32'd56);
    run_r();
    chk("R5 sub result", alu_out, 32'd2);
    run_r();
    chk("R5 and result", alu_out, 32'd5);
    run_r();
    chk("R5 or result", alu_out, 32'd7);
    chk("R11 opcode of R-type", {26'b0, opcode}, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      c = ctl_t'($urandom);
      cyc(c, "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule